// File: doc/BRIEF.md
# Line-doubling VGA scanout engine

This block generates raster timing for an 800x600, 60 Hz VGA display. It drives positive horizontal and vertical sync and an 8-bit RGB332 colour output: 3 bits red, 3 bits green and 2 bits blue, 256 colours. Pixels come from a smaller frame buffer, 703x300 by default, through a synchronous read port with one cycle of latency. The block issues the read address one clock ahead of each pixel.

Row repetition can be switched on or off. When it is on, each buffer row appears on two consecutive scan lines, so 300 rows fill the 600-line raster. When it is off, each row appears once. The unused lines are then black, and they are split evenly into a band above the image and a band below it. A programmable shift sets the left black border. A programmable pixel count sets how many buffer pixels each line shows, and the rest of the line is black. Wherever no buffer pixel is shown, including both sync intervals, the colour output is zero. The block takes its configuration only at frame boundaries, so a frame never tears.

Top module: `vga_scanout`

## Requirements
- R1: While rst_ni is low, and for the first two clocks after it rises, hsync_o, vsync_o and rgb_o are 0.
- R2: A line lasts H_VIS+H_FP+H_SYNC+H_BP clocks (1056 by default). Each line starts with its first visible pixel. hsync_o is high (positive pulse) for H_SYNC clocks, starting H_VIS+H_FP clocks after the line start.
- R3: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines (628 by default). vsync_o is high for V_SYNC whole lines, starting V_FP lines after the last visible line.
- R4: Read port timing. For raster position n (line-major, counted from reset release, with the frame origin at n=0), rd_en_o is high in cycle n when the position shows a buffer pixel. In that case rd_addr_o = row*FB_W + col. rd_data_i is captured one cycle later, and the pixel's colour appears on rgb_o two cycles after n, aligned with that position's sync values.
- R5: With row repetition on (row_rep=1), visible line v shows buffer row v/2. Lines with v/2 >= FB_H are black.
- R6: With row repetition off, the image starts at line T=(V_VIS-FB_H)/2. Line v shows row v-T for T <= v < T+FB_H, and all other visible lines are black.
- R7: Visible column h shows buffer column h-shift when shift <= h < shift+limit, where limit = min(count, FB_W). The left border (h < shift) and the right remainder of the line are black.
- R8: A count above FB_W is treated as FB_W. When shift+limit runs past H_VIS, no pixel is read or shown at or after column H_VIS.
- R9: Outside the active window, including all sync and porch intervals, rd_en_o is 0 and rgb_o is 0.
- R10: row_rep_i, hshift_i and hcount_i are sampled only on the last clock of a frame and apply to the whole next frame. Changes at other times have no effect. After reset the first frame uses repetition on, shift 0 and count FB_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_rep_i | input | 1 | 1: show each buffer row twice; 0: show once with letterbox bands |
| hshift_i | input | HW | Left border width in pixels (HW = clog2 of line length) |
| hcount_i | input | HW | Buffer pixels shown per line |
| rd_en_o | output | 1 | Frame buffer read strobe |
| rd_addr_o | output | AW | Frame buffer address, row*FB_W+col (AW = clog2(FB_W*FB_H)) |
| rd_data_i | input | 8 | Read data, valid the cycle after rd_en_o |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| rgb_o | output | 8 | RGB332 pixel, zero outside the active window |

## Verification
The assertions check on every cycle that the colour is zero during both sync pulses and that every read address lies inside the buffer. They also check that a non-zero colour always follows a read issued two cycles earlier, that each hsync pulse has the programmed width, and that the line period is correct. Other behaviour depends on the configuration and needs the bench scenarios to show it. This covers the row mapping with repetition on and off, the letterbox band placement, the left shift, the count and overrun clipping, and the rule that configuration changes wait for the frame boundary. The bench checks these by comparing every read address and every output pixel against a model of the raster.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
  typedef logic [7:0] rgb332_t;
  localparam rgb332_t RGB_BLACK = 8'h00;

  typedef struct packed {
    logic hs;
    logic vs;
  } sync_t;
endpackage

// File: rtl/vga_scan_timing.sv
module vga_scan_timing #(
  parameter int H_VIS  = 800,
  parameter int H_FP   = 40,
  parameter int H_SYNC = 128,
  parameter int H_BP   = 88,
  parameter int V_VIS  = 600,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 4,
  parameter int V_BP   = 23,
  parameter int HW     = $clog2(H_VIS + H_FP + H_SYNC + H_BP),
  parameter int VW     = $clog2(V_VIS + V_FP + V_SYNC + V_BP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic          hs_o,
  output logic          vs_o,
  output logic          frame_last_o
);
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [HW-1:0] HS_BEG = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_BEG = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_VIS + V_FP + V_SYNC);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          line_last;

  assign line_last = (h_q == H_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (line_last) begin
      h_q <= '0;
      v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_o          = h_q;
  assign v_o          = v_q;
  assign hs_o         = (h_q >= HS_BEG) && (h_q < HS_END);
  assign vs_o         = (v_q >= VS_BEG) && (v_q < VS_END);
  assign frame_last_o = line_last && (v_q == V_LAST);
endmodule

// File: rtl/vga_scan_rowmap.sv
module vga_scan_rowmap #(
  parameter int V_VIS = 600,
  parameter int FB_H  = 300,
  parameter int VW    = 10,
  parameter int RW    = $clog2(FB_H)
) (
  input  logic [VW-1:0] v_i,
  input  logic          rep_i,
  output logic          ok_o,
  output logic [RW-1:0] row_o
);
  localparam int REP_LINES = (2 * FB_H < V_VIS) ? 2 * FB_H : V_VIS;
  localparam logic [VW-1:0] REP_END = VW'(REP_LINES);
  localparam logic [VW-1:0] TOP_L   = VW'((V_VIS - FB_H) / 2);
  localparam logic [VW-1:0] BOT_L   = VW'((V_VIS - FB_H) / 2 + FB_H);

  logic [VW-1:0] v_half;
  logic [VW-1:0] v_off;

  assign v_half = v_i >> 1;
  assign v_off  = v_i - TOP_L;

  always_comb begin
    if (rep_i) begin
      ok_o  = (v_i < REP_END);
      row_o = RW'(v_half);
    end else begin
      ok_o  = (v_i >= TOP_L) && (v_i < BOT_L);
      row_o = RW'(v_off);
    end
  end
endmodule

// File: rtl/vga_scan_colmap.sv
module vga_scan_colmap #(
  parameter int H_VIS = 800,
  parameter int FB_W  = 703,
  parameter int HW    = 11,
  parameter int CW    = $clog2(FB_W)
) (
  input  logic [HW-1:0] h_i,
  input  logic [HW-1:0] shift_i,
  input  logic [HW-1:0] count_i,
  output logic          ok_o,
  output logic [CW-1:0] col_o
);
  localparam logic [HW-1:0] FBW_L  = HW'(FB_W);
  localparam logic [HW-1:0] HVIS_L = HW'(H_VIS);

  logic [HW-1:0] lim;
  logic [HW-1:0] off;

  assign lim   = (count_i > FBW_L) ? FBW_L : count_i;
  assign off   = h_i - shift_i;
  assign ok_o  = (h_i >= shift_i) && (off < lim) && (h_i < HVIS_L);
  assign col_o = CW'(off);
endmodule

// File: rtl/vga_scanout.sv
module vga_scanout #(
  parameter int H_VIS  = 800,
  parameter int H_FP   = 40,
  parameter int H_SYNC = 128,
  parameter int H_BP   = 88,
  parameter int V_VIS  = 600,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 4,
  parameter int V_BP   = 23,
  parameter int FB_W   = 703,
  parameter int FB_H   = 300,
  parameter int HW     = $clog2(H_VIS + H_FP + H_SYNC + H_BP),
  parameter int VW     = $clog2(V_VIS + V_FP + V_SYNC + V_BP),
  parameter int AW     = $clog2(FB_W * FB_H)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   row_rep_i,
  input  logic [HW-1:0]          hshift_i,
  input  logic [HW-1:0]          hcount_i,
  output logic                   rd_en_o,
  output logic [AW-1:0]          rd_addr_o,
  input  vga_scan_pkg::rgb332_t  rd_data_i,
  output logic                   hsync_o,
  output logic                   vsync_o,
  output vga_scan_pkg::rgb332_t  rgb_o
);
  import vga_scan_pkg::*;

  localparam int RW = $clog2(FB_H);
  localparam int CW = $clog2(FB_W);
  localparam logic [AW-1:0] FBW_A = AW'(FB_W);
  localparam logic [HW-1:0] CNT_RST = HW'(FB_W);

  logic [HW-1:0] h;
  logic [VW-1:0] v;
  logic          hs_raw, vs_raw, frame_last;

  // frame-stable configuration
  logic          rep_q;
  logic [HW-1:0] shift_q, count_q;

  logic          row_ok, col_ok;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [AW-1:0] addr;

  sync_t   sync_s1, sync_s2;
  logic    act_s1;
  rgb332_t rgb_s2;

  vga_scan_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HW(HW), .VW(VW)
  ) u_timing (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .h_o          (h),
    .v_o          (v),
    .hs_o         (hs_raw),
    .vs_o         (vs_raw),
    .frame_last_o (frame_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q   <= 1'b1;
      shift_q <= '0;
      count_q <= CNT_RST;
    end else if (frame_last) begin
      rep_q   <= row_rep_i;
      shift_q <= hshift_i;
      count_q <= hcount_i;
    end
  end

  vga_scan_rowmap #(
    .V_VIS(V_VIS), .FB_H(FB_H), .VW(VW), .RW(RW)
  ) u_rowmap (
    .v_i   (v),
    .rep_i (rep_q),
    .ok_o  (row_ok),
    .row_o (row)
  );

  vga_scan_colmap #(
    .H_VIS(H_VIS), .FB_W(FB_W), .HW(HW), .CW(CW)
  ) u_colmap (
    .h_i     (h),
    .shift_i (shift_q),
    .count_i (count_q),
    .ok_o    (col_ok),
    .col_o   (col)
  );

  assign addr      = AW'(row) * FBW_A + AW'(col);
  assign rd_en_o   = row_ok && col_ok;
  assign rd_addr_o = rd_en_o ? addr : '0;

  // stage 1: read in flight; stage 2: data registered to the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_s1  <= 1'b0;
      sync_s1 <= '0;
      sync_s2 <= '0;
      rgb_s2  <= RGB_BLACK;
    end else begin
      act_s1  <= rd_en_o;
      sync_s1 <= '{hs: hs_raw, vs: vs_raw};
      sync_s2 <= sync_s1;
      rgb_s2  <= act_s1 ? rd_data_i : RGB_BLACK;
    end
  end

  assign hsync_o = sync_s2.hs;
  assign vsync_o = sync_s2.vs;
  assign rgb_o   = rgb_s2;
endmodule

// File: rtl/vga_scanout_chk.sv
module vga_scanout_chk #(
  parameter int H_TOT  = 1056,
  parameter int H_SYNC = 128,
  parameter int FB_W   = 703,
  parameter int FB_H   = 300,
  parameter int AW     = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic [7:0]    rgb_o,
  input logic          rd_en_o,
  input logic [AW-1:0] rd_addr_o
);
  localparam int FB_N = FB_W * FB_H;

  logic [15:0] hs_len, line_len;
  logic        hs_prev, seen_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_len    <= '0;
      line_len  <= '0;
      hs_prev   <= 1'b0;
      seen_rise <= 1'b0;
    end else begin
      hs_prev  <= hsync_o;
      hs_len   <= hsync_o ? hs_len + 1'b1 : '0;
      if (hsync_o && !hs_prev) begin
        line_len  <= 16'd1;
        seen_rise <= 1'b1;
      end else begin
        line_len <= line_len + 1'b1;
      end
    end
  end

  AST_HS_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> (rgb_o == 8'h00)); // R9
  AST_VS_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> (rgb_o == 8'h00)); // R9
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (int'(rd_addr_o) < FB_N)); // R4
  AST_RGB_FROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rgb_o != 8'h00) |-> $past(rd_en_o, 2)); // R4
  AST_HS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_prev && !hsync_o) |-> (hs_len == 16'(H_SYNC))); // R2
  AST_LINE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_o && !hs_prev && seen_rise) |-> (line_len == 16'(H_TOT))); // R2
endmodule

bind vga_scanout vga_scanout_chk #(
  .H_TOT  (H_VIS + H_FP + H_SYNC + H_BP),
  .H_SYNC (H_SYNC),
  .FB_W   (FB_W),
  .FB_H   (FB_H),
  .AW     (AW)
) u_chk (.*);

// File: tb/vga_scanout_tb.sv
`timescale 1ns/1ps
module vga_scanout_tb;
  localparam int H_VIS = 40, H_FP = 2, H_SYNC = 4, H_BP = 4;
  localparam int V_VIS = 24, V_FP = 1, V_SYNC = 2, V_BP = 2;
  localparam int HT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int VT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int FB_W = 30, FB_H = 10;
  localparam int FT = HT * VT;
  localparam int NF = 36;
  localparam int HW = $clog2(HT);
  localparam int AW = $clog2(FB_W * FB_H);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic          row_rep_i = 1'b1;
  logic [HW-1:0] hshift_i = '0;
  logic [HW-1:0] hcount_i = '0;
  logic          rd_en_o;
  logic [AW-1:0] rd_addr_o;
  logic [7:0]    rd_data_i = 8'h00;
  logic          hsync_o, vsync_o;
  logic [7:0]    rgb_o;

  int    rep_p [NF+1];
  int    sh_p  [NF+1];
  int    cnt_p [NF+1];
  string tag_p [NF+1];
  int    k = 0;
  bit    run = 1'b0;
  bit    done = 1'b0;
  int    checks = 0;
  int    failures = 0;

  always #2.5 clk_i = ~clk_i;

  vga_scanout #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .FB_W(FB_W), .FB_H(FB_H)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .row_rep_i(row_rep_i),
    .hshift_i(hshift_i), .hcount_i(hcount_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .rgb_o(rgb_o)
  );

  function automatic logic [7:0] memf(input int a);
    return 8'((a * 29 + 11) ^ (a >> 3));
  endfunction

  // frame buffer: one cycle read latency; junk when not read
  always @(posedge clk_i) rd_data_i <= rd_en_o ? memf(int'(rd_addr_o)) : 8'h5A;

  always @(posedge clk_i) if (run) k <= k + 1;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d cycle=%0d", tag, what, act, exp, k);
    end
  endtask

  task automatic model(input int n, output bit en, output int addr,
                       output bit hs, output bit vs, output int fr);
    int p, h, v, row, col, lim, top;
    bit rok, cok;
    en = 0; addr = 0; hs = 0; vs = 0; fr = 0;
    if (n >= 0) begin
      fr = n / FT;
      p  = n % FT;
      h  = p % HT;
      v  = p / HT;
      hs = (h >= H_VIS + H_FP) && (h < H_VIS + H_FP + H_SYNC);
      vs = (v >= V_VIS + V_FP) && (v < V_VIS + V_FP + V_SYNC);
      if (rep_p[fr] != 0) begin
        row = v / 2;
        rok = (v < V_VIS) && (row < FB_H);
      end else begin
        top = (V_VIS - FB_H) / 2;
        row = v - top;
        rok = (v >= top) && (row < FB_H) && (v < V_VIS);
      end
      lim = (cnt_p[fr] < FB_W) ? cnt_p[fr] : FB_W;
      col = h - sh_p[fr];
      cok = (h >= sh_p[fr]) && (col < lim) && (h < H_VIS);
      en  = rok && cok;
      addr = en ? row * FB_W + col : 0;
    end
  endtask

  task automatic check_cycle();
    bit en, hs, vs, en2, hs2, vs2;
    int addr, fr, addr2, fr2, exp_rgb;
    string tag;
    model(k, en, addr, hs, vs, fr);
    chk("R4", "rd_en", int'(rd_en_o), int'(en));
    if (en) chk("R4", "rd_addr", int'(rd_addr_o), addr);
    model(k - 2, en2, addr2, hs2, vs2, fr2);
    exp_rgb = en2 ? int'(memf(addr2)) : 0;
    tag = (k < 2) ? "R1" : tag_p[fr2];
    chk((k < 2) ? "R1" : "R2", "hsync", int'(hsync_o), int'(hs2));
    chk((k < 2) ? "R1" : "R3", "vsync", int'(vsync_o), int'(vs2));
    chk(tag, "rgb", int'(rgb_o), exp_rgb);
  endtask

  always @(negedge clk_i) if (run && !done) check_cycle();

  task automatic set_plan(input int f, input int rep, input int sh, input int cnt, input string tag);
    rep_p[f] = rep; sh_p[f] = sh; cnt_p[f] = cnt; tag_p[f] = tag;
  endtask

  task automatic drive_plan(input int f);
    row_rep_i = rep_p[f][0];
    hshift_i  = HW'(sh_p[f]);
    hcount_i  = HW'(cnt_p[f]);
  endtask

  task automatic wait_k(input int target);
    while (k < target) @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'd4711));
    set_plan(0, 1, 0, FB_W, "R10");   // reset defaults
    set_plan(1, 1, 5, 30, "R5");
    set_plan(2, 0, 5, 30, "R6");
    set_plan(3, 1, 20, 30, "R8");     // shift+count past visible area
    set_plan(4, 0, 3, 63, "R8");      // count above buffer width
    set_plan(5, 1, 0, 0, "R9");       // nothing shown
    set_plan(6, 0, 39, 1, "R7");      // single last visible column
    set_plan(7, 1, 45, 30, "R9");     // shift beyond visible area
    set_plan(8, 1, 12, 17, "R7");
    for (int f = 9; f <= NF; f++) begin
      int rep, sh, cnt, lim;
      rep = int'($urandom % 2);
      sh  = int'($urandom % 48);
      cnt = int'($urandom % 64);
      lim = (cnt < FB_W) ? cnt : FB_W;
      set_plan(f, rep, sh, cnt, (sh + lim > H_VIS) ? "R8" : (rep != 0 ? "R5" : "R6"));
    end

    #1 rst_ni = 1'b0;
    repeat (4) begin
      @(negedge clk_i);
      chk("R1", "hsync in reset", int'(hsync_o), 0);
      chk("R1", "vsync in reset", int'(vsync_o), 0);
      chk("R1", "rgb in reset", int'(rgb_o), 0);
    end
    drive_plan(1);
    rst_ni = 1'b1;
    run = 1'b1;

    for (int f = 0; f < NF; f++) begin
      wait_k(f * FT + 5);
      // R10: mid-frame junk must not reach the raster
      row_rep_i = 1'($urandom % 2);
      hshift_i  = HW'($urandom % 64);
      hcount_i  = HW'($urandom % 64);
      wait_k(f * FT + FT / 2);
      drive_plan(f + 1);
    end
    wait_k(NF * FT);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (120000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL R4 watchdog act=%0d exp=%0d", k, NF * FT);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule